// File: doc/BRIEF.md
# Latched Low-Battery Alarm Controller

This block watches the most recent state-of-charge estimate and battery voltage code. It raises an active-low, open-drain alarm when either value falls under its programmable threshold. The two conditions are low charge and low voltage. Each one owns a sticky status flag. Software must write each flag back to zero. After a flag is cleared, that condition can fire again only if it has first gone away and then come back. A separate override bit lets software pull the pin low directly. The raw pin level is returned so that software can read it. Computing the charge and voltage values happens elsewhere.

The two measurement inputs arrive as valid/ready streams. The block never applies back-pressure: both ready outputs stay high, and a value is taken on every cycle in which its valid is high. The block holds the last accepted value of each stream. It compares the held value against the threshold inputs as they stand in each cycle. Until at least one value of each kind has been accepted, the alarm logic stays idle and the pin is released, except when the override pulls it low.

Top module: `lowbat_alarm`

## Requirements
- R1: After reset both flags read 0 and `alm_pull_low` is 0 (pin released) while `alm_release` is 1.
- R2: Until one charge value and one voltage value have both been accepted, no flag sets, and `alm_pull_low` equals the inverse of `alm_release`.
- R3: The charge value is in 1/512 % units and `soc_thr` is in 0.5 % units. When the held charge value is strictly less than `soc_thr`*256, `alarm_en` is 1 and the charge condition is armed, `soc_flag` is 1 one cycle later. Equality does not trigger.
- R4: The voltage code is in 2.2 mV units and `volt_thr` is in 17.6 mV units. When the held voltage code is strictly less than `volt_thr`*8, `alarm_en` is 1 and the voltage condition is armed, `volt_flag` is 1 one cycle later. Equality does not trigger.
- R5: A set flag stays 1, even after its condition goes away, until its clear strobe is seen.
- R6: A one-cycle clear strobe (`clr_soc` or `clr_volt`) clears its flag at the next edge. The pin is released only once both flags are 0.
- R7: A flag cleared while its condition is still present stays 0 until the condition has been false for at least one cycle and then becomes true again.
- R8: `alm_pull_low` is 1 whenever `alm_release` is 0, or whenever `alarm_en` is 1 and either flag is 1. Otherwise it is 0.
- R9: While one flag is latched, the other condition still sets its own flag independently.
- R10: `pin_status` mirrors `alm_pin_sense`, the sensed pin level.
- R11: With `alarm_en` at 0, no flag sets and latched flags do not pull the pin. Raising `alarm_en` with an armed condition present sets its flag one cycle later.
- R12: `soc_ready` and `volt_ready` are always 1. A value on `soc_value` or `volt_value` without its valid is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soc_valid | input | 1 | Charge value valid |
| soc_ready | output | 1 | Charge value ready (always 1) |
| soc_value | input | SOC_W | Charge estimate, 1/512 % per LSB |
| volt_valid | input | 1 | Voltage code valid |
| volt_ready | output | 1 | Voltage code ready (always 1) |
| volt_value | input | VOLT_W | Voltage code, 2.2 mV per LSB |
| soc_thr | input | THR_W | Charge threshold, 0.5 % per LSB |
| volt_thr | input | THR_W | Voltage threshold, 17.6 mV per LSB |
| alarm_en | input | 1 | Alarm enable |
| alm_release | input | 1 | Override: 0 forces the pin low |
| clr_soc | input | 1 | Clear strobe for the charge flag |
| clr_volt | input | 1 | Clear strobe for the voltage flag |
| alm_pin_sense | input | 1 | Sensed level of the alarm pin |
| alm_pull_low | output | 1 | 1 pulls the open-drain pin low |
| pin_status | output | 1 | Readback of the pin level |
| soc_flag | output | 1 | Low-charge status flag |
| volt_flag | output | 1 | Low-voltage status flag |

## Verification
The bench targets the exact threshold values, where a design comparing with less-or-equal, or scaling by the wrong shift, would fire one step early or late. It also covers clearing a flag while its condition persists: a design without re-arm tracking would set the flag again at once. Further cases are a second condition that trips while the first is latched, which a shared flag would miss, and samples that arrive before the other stream has delivered, which a design lacking the start gate would act on. Random stretches then compare every cycle against a bench-side model of the flags and pin.

// File: rtl/lowbat_pkg.sv
`timescale 1ns/1ps
package lowbat_pkg;
  localparam int CH_SOC   = 0;
  localparam int CH_VOLT  = 1;
  localparam int CH_COUNT = 2;
endpackage

// File: rtl/lowbat_capture.sv
`timescale 1ns/1ps
module lowbat_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [W-1:0] data,
  output logic [W-1:0] held,
  output logic         seen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      seen <= 1'b0;
    end else if (valid) begin
      held <= data;
      seen <= 1'b1;
    end
  end
endmodule

// File: rtl/lowbat_compare.sv
`timescale 1ns/1ps
module lowbat_compare #(
  parameter int VW    = 16,
  parameter int TW    = 8,
  parameter int SHIFT = 8
) (
  input  logic [VW-1:0] value,
  input  logic [TW-1:0] thr,
  output logic          below
);
  localparam int EW = (TW + SHIFT > VW) ? (TW + SHIFT) : VW;
  logic [EW-1:0] val_x;
  logic [EW-1:0] thr_x;
  assign val_x = EW'(value);
  assign thr_x = EW'({thr, {SHIFT{1'b0}}});
  assign below = (val_x < thr_x);
endmodule

// File: rtl/lowbat_latch.sv
`timescale 1ns/1ps
module lowbat_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  output logic flag,
  output logic armed
);
  // armed: condition has been seen false since the last trigger
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b1;
    end else if (cond && armed) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else begin
      if (clr)   flag  <= 1'b0;
      if (!cond) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/lowbat_alarm.sv
`timescale 1ns/1ps
module lowbat_alarm
  import lowbat_pkg::*;
#(
  parameter int SOC_W      = 16,
  parameter int VOLT_W     = 12,
  parameter int THR_W      = 8,
  parameter int SOC_SHIFT  = 8,
  parameter int VOLT_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soc_valid,
  output logic              soc_ready,
  input  logic [SOC_W-1:0]  soc_value,
  input  logic              volt_valid,
  output logic              volt_ready,
  input  logic [VOLT_W-1:0] volt_value,
  input  logic [THR_W-1:0]  soc_thr,
  input  logic [THR_W-1:0]  volt_thr,
  input  logic              alarm_en,
  input  logic              alm_release,
  input  logic              clr_soc,
  input  logic              clr_volt,
  input  logic              alm_pin_sense,
  output logic              alm_pull_low,
  output logic              pin_status,
  output logic              soc_flag,
  output logic              volt_flag
);
  logic [SOC_W-1:0]  soc_q;
  logic [VOLT_W-1:0] volt_q;
  logic              soc_seen;
  logic              volt_seen;
  logic              started;
  logic [CH_COUNT-1:0] below_vec;
  logic [CH_COUNT-1:0] cond_vec;
  logic [CH_COUNT-1:0] clr_vec;
  logic [CH_COUNT-1:0] flag_vec;
  logic [CH_COUNT-1:0] armed_vec;

  assign soc_ready  = 1'b1;
  assign volt_ready = 1'b1;

  lowbat_capture #(.W(SOC_W)) u_soc_cap (
    .clk(clk), .rst_n(rst_n), .valid(soc_valid), .data(soc_value),
    .held(soc_q), .seen(soc_seen)
  );

  lowbat_capture #(.W(VOLT_W)) u_volt_cap (
    .clk(clk), .rst_n(rst_n), .valid(volt_valid), .data(volt_value),
    .held(volt_q), .seen(volt_seen)
  );

  assign started = soc_seen & volt_seen;

  assign clr_vec[CH_SOC]  = clr_soc;
  assign clr_vec[CH_VOLT] = clr_volt;

  for (genvar gi = 0; gi < CH_COUNT; gi++) begin : g_ch
    if (gi == CH_SOC) begin : g_cmp
      lowbat_compare #(.VW(SOC_W), .TW(THR_W), .SHIFT(SOC_SHIFT)) u_cmp (
        .value(soc_q), .thr(soc_thr), .below(below_vec[gi])
      );
    end else begin : g_cmp
      lowbat_compare #(.VW(VOLT_W), .TW(THR_W), .SHIFT(VOLT_SHIFT)) u_cmp (
        .value(volt_q), .thr(volt_thr), .below(below_vec[gi])
      );
    end
    assign cond_vec[gi] = started & alarm_en & below_vec[gi];
    lowbat_latch u_latch (
      .clk(clk), .rst_n(rst_n), .cond(cond_vec[gi]), .clr(clr_vec[gi]),
      .flag(flag_vec[gi]), .armed(armed_vec[gi])
    );
  end

  assign soc_flag     = flag_vec[CH_SOC];
  assign volt_flag    = flag_vec[CH_VOLT];
  assign alm_pull_low = ~alm_release | (alarm_en & (|flag_vec));
  assign pin_status   = alm_pin_sense;
endmodule

// File: rtl/lowbat_alarm_chk.sv
`timescale 1ns/1ps
module lowbat_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       started,
  input logic [1:0] cond_vec,
  input logic [1:0] armed_vec,
  input logic       soc_flag,
  input logic       volt_flag,
  input logic       clr_soc,
  input logic       clr_volt,
  input logic       alarm_en,
  input logic       alm_release,
  input logic       alm_pull_low
);
  assert_idle_before_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (alm_pull_low == !alm_release) && !soc_flag && !volt_flag);

  assert_soc_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cond_vec[0] && armed_vec[0] |=> soc_flag);

  assert_volt_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cond_vec[1] && armed_vec[1] |=> volt_flag);

  assert_soc_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soc_flag && !clr_soc |=> soc_flag);

  assert_volt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    volt_flag && !clr_volt |=> volt_flag);

  assert_soc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_soc && !(cond_vec[0] && armed_vec[0]) |=> !soc_flag);

  assert_volt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_volt && !(cond_vec[1] && armed_vec[1]) |=> !volt_flag);

  assert_soc_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_vec[0]) |-> !$past(cond_vec[0]));

  assert_volt_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_vec[1]) |-> !$past(cond_vec[1]));

  assert_pull_on_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_en && (soc_flag || volt_flag) |-> alm_pull_low);

  assert_release_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alm_release && !soc_flag && !volt_flag |-> !alm_pull_low);

  assert_no_set_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en && !soc_flag && !volt_flag |=> !soc_flag && !volt_flag);
endmodule

bind lowbat_alarm lowbat_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .started(started), .cond_vec(cond_vec),
  .armed_vec(armed_vec), .soc_flag(soc_flag), .volt_flag(volt_flag),
  .clr_soc(clr_soc), .clr_volt(clr_volt), .alarm_en(alarm_en),
  .alm_release(alm_release), .alm_pull_low(alm_pull_low)
);

// File: tb/sim_lowbat_alarm.sv
`timescale 1ns/1ps
module sim_lowbat_alarm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soc_valid = 0, volt_valid = 0;
  logic soc_ready, volt_ready;
  logic [15:0] soc_value = '0;
  logic [11:0] volt_value = '0;
  logic [7:0] soc_thr = 8'd2, volt_thr = 8'd170;
  logic alarm_en = 1, alm_release = 1, clr_soc = 0, clr_volt = 0, alm_pin_sense = 1;
  logic alm_pull_low, pin_status, soc_flag, volt_flag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lowbat_alarm u0 (
    .clk(clk), .rst_n(rst_n), .soc_valid(soc_valid), .soc_ready(soc_ready),
    .soc_value(soc_value), .volt_valid(volt_valid), .volt_ready(volt_ready),
    .volt_value(volt_value), .soc_thr(soc_thr), .volt_thr(volt_thr),
    .alarm_en(alarm_en), .alm_release(alm_release), .clr_soc(clr_soc),
    .clr_volt(clr_volt), .alm_pin_sense(alm_pin_sense),
    .alm_pull_low(alm_pull_low), .pin_status(pin_status),
    .soc_flag(soc_flag), .volt_flag(volt_flag)
  );

  function automatic bit soc_low(int v, int t);
    return v < t * 256;
  endfunction
  function automatic bit volt_low(int v, int t);
    return v < t * 8;
  endfunction

  // bench-side model of flags, re-arm state and held samples
  int m_soc = 0, m_volt = 0;
  bit m_sseen = 0, m_vseen = 0, m_fs = 0, m_fv = 0, m_as = 1, m_av = 1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_soc <= 0; m_volt <= 0; m_sseen <= 0; m_vseen <= 0;
      m_fs <= 0; m_fv <= 0; m_as <= 1; m_av <= 1;
    end else begin
      bit cs, cv;
      cs = m_sseen && m_vseen && alarm_en && soc_low(m_soc, int'(soc_thr));
      cv = m_sseen && m_vseen && alarm_en && volt_low(m_volt, int'(volt_thr));
      if (cs && m_as) begin m_fs <= 1; m_as <= 0; end
      else begin if (clr_soc) m_fs <= 0; if (!cs) m_as <= 1; end
      if (cv && m_av) begin m_fv <= 1; m_av <= 0; end
      else begin if (clr_volt) m_fv <= 0; if (!cv) m_av <= 1; end
      if (soc_valid) begin m_soc <= int'(soc_value); m_sseen <= 1; end
      if (volt_valid) begin m_volt <= int'(volt_value); m_vseen <= 1; end
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_model(string tag);
    chk({tag, " soc_flag"}, soc_flag, m_fs);
    chk({tag, " volt_flag"}, volt_flag, m_fv);
    chk({tag, " pull"}, alm_pull_low, !alm_release || (alarm_en && (m_fs || m_fv)));
    chk({tag, " status"}, pin_status, alm_pin_sense);
  endtask

  task automatic put_soc(int v);
    soc_value = 16'(v); soc_valid = 1;
    @(negedge clk); soc_valid = 0;
    @(negedge clk); @(negedge clk);
  endtask
  task automatic put_volt(int v);
    volt_value = 12'(v); volt_valid = 1;
    @(negedge clk); volt_valid = 0;
    @(negedge clk); @(negedge clk);
  endtask
  task automatic pulse_soc();
    clr_soc = 1; @(negedge clk); clr_soc = 0; @(negedge clk);
  endtask
  task automatic pulse_volt();
    clr_volt = 1; @(negedge clk); clr_volt = 0; @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 soc_flag", soc_flag, 0);
    chk("R1 volt_flag", volt_flag, 0);
    chk("R1 pull", alm_pull_low, 0);
    // R2 no action before both streams delivered
    put_soc(100);
    chk("R2 soc_flag", soc_flag, 0);
    chk("R2 pull", alm_pull_low, 0);
    alm_release = 0; @(negedge clk);
    chk("R2 override", alm_pull_low, 1);
    alm_release = 1; @(negedge clk);
    // R3 trigger after start
    put_volt(2000);
    chk("R3 soc_flag", soc_flag, 1);
    chk("R3 pull", alm_pull_low, 1);
    chk("R9 volt_flag idle", volt_flag, 0);
    // R5 sticky
    put_soc(5000);
    chk("R5 soc_flag", soc_flag, 1);
    chk("R5 pull", alm_pull_low, 1);
    // R6 clear
    pulse_soc();
    chk("R6 soc_flag", soc_flag, 0);
    chk("R6 pull", alm_pull_low, 0);
    // R3 boundary
    put_soc(512);
    chk("R3 equal", soc_flag, 0);
    put_soc(511);
    chk("R3 below", soc_flag, 1);
    // R4 boundary and R9 independence
    put_volt(1360);
    chk("R4 equal", volt_flag, 0);
    put_volt(1359);
    chk("R4 below", volt_flag, 1);
    chk("R9 soc held", soc_flag, 1);
    // R7 clear while present
    pulse_soc();
    chk("R7 cleared", soc_flag, 0);
    repeat (5) @(negedge clk);
    chk("R7 no retrigger", soc_flag, 0);
    chk("R8 volt pulls", alm_pull_low, 1);
    pulse_volt();
    chk("R6 volt cleared", volt_flag, 0);
    chk("R6 released", alm_pull_low, 0);
    put_soc(600);
    chk("R7 gone", soc_flag, 0);
    put_soc(400);
    chk("R7 retrigger", soc_flag, 1);
    // R11 enable
    alarm_en = 0; @(negedge clk);
    chk("R11 mask", alm_pull_low, 0);
    chk("R11 flag kept", soc_flag, 1);
    pulse_soc();
    put_soc(600);
    put_soc(100);
    chk("R11 no set", soc_flag, 0);
    alarm_en = 1; @(negedge clk);
    chk("R11 set on enable", soc_flag, 1);
    pulse_soc();
    // R12 ignored without valid
    put_soc(3000);
    soc_value = 16'd10;
    repeat (3) @(negedge clk);
    chk("R12 ignored", soc_flag, 0);
    chk("R12 soc_ready", soc_ready, 1);
    chk("R12 volt_ready", volt_ready, 1);
    // R10 pin readback
    alm_pin_sense = 0; @(negedge clk);
    chk("R10 low", pin_status, 0);
    alm_pin_sense = 1; @(negedge clk);
    chk("R10 high", pin_status, 1);
    chk_model("R8 directed");
    // random phase against model
    for (int i = 0; i < 3000; i++) begin
      soc_valid = ($urandom_range(0, 3) == 0);
      soc_value = 16'($urandom_range(0, 1300));
      volt_valid = ($urandom_range(0, 3) == 0);
      volt_value = 12'($urandom_range(1300, 1420));
      if ($urandom_range(0, 63) == 0) soc_thr = 8'($urandom_range(1, 4));
      if ($urandom_range(0, 63) == 0) volt_thr = 8'($urandom_range(165, 176));
      clr_soc = ($urandom_range(0, 15) == 0);
      clr_volt = ($urandom_range(0, 15) == 0);
      alarm_en = ($urandom_range(0, 15) != 0);
      alm_release = ($urandom_range(0, 15) != 0);
      alm_pin_sense = 1'($urandom_range(0, 1));
      @(negedge clk);
      chk_model("R8 random");
    end
    finish_run();
  end
endmodule